// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A synthesizable behavioural model of a single-port synchronous static memory whose shared data bus never needs an idle cycle between a read and a write. Each access is latched on a rising clock edge when the load strobe is low. Both directions then share one fixed latency: read data is on the bus in the second cycle after the command cycle, and write data is taken from the bus at the end of that same slot. A host can therefore issue any mix of reads and writes on consecutive cycles.

Besides single accesses, the block offers 4-beat bursts inside an aligned group of four words, in linear or interleaved order, plus per-lane write masking. It also has a clock-stall input that freezes the whole block for one edge, three chip selects, an asynchronous output enable and a sleep input that keeps the stored contents. Writes that are still waiting for their data are forwarded, lane by lane, to any read of the same word. The bus is split into `din`, `dout` and a drive strobe `dout_oe`.

Top module: `pipe_sram`

## Requirements
- R1: With `load_n` low, `sel_a_n` low, `sel_b` high and `sel_c_n` low at an edge, a read of `addr` is latched. `dout_oe` is high and `dout` holds the word during the cycle that follows the next edge, so reads and writes may be issued on back-to-back cycles.
- R2: A write latched at edge k takes its data from `din` at edge k+2.
- R3: While `stall` is high, the edge has no effect: no command is latched, `dout` and `dout_oe` keep their values, and a write waiting for data is carried out at the next edge with `stall` low.
- R4: A load with any chip select inactive is a deselect, and its output slot has `dout_oe` low. A cycle with `load_n` high after a deselect also stays deselected.
- R5: `lane_n[0]` low enables bits 8:0 and `lane_n[1]` low enables bits 17:9 of a write. A write with both high writes nothing.
- R6: `out_en_n` high forces `dout_oe` low at once, with no clock edge. The pipeline keeps running, so lowering it again shows the read data that is due.
- R7: While `sleep` is high, `dout_oe` is low, loads are ignored and memory contents stay unchanged. After release, cycles with `load_n` high stay deselected until a new load.
- R8: A cycle with `load_n` high after a selected load continues the burst. Address bits above bit 1 stay fixed. With `burst_ilv` low, beat k (k = 0 to 3) uses low bits (a+k) mod 4; with it high, a xor k. Each write beat takes `lane_n` fresh.
- R9: A read of a word whose write is still waiting for its data returns that write's enabled lanes from `din` merged with the stored bits of the other lanes.
- R10: Synchronous `rst` empties the pipeline and ends any burst. `dout_oe` is low after it, and a write pending at reset is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Ignore this clock edge when high |
| load_n | input | 1 | Low: latch a new access; high: continue the burst |
| wr_n | input | 1 | Low: write, high: read (used on loads) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address (used on loads) |
| din | input | LANES*LANE_W | Write data, due two cycles after the write command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| dout | output | LANES*LANE_W | Read data |
| dout_oe | output | 1 | High when the block drives the bus |

## Verification
The bench counts clock edges from each command and changes inputs and samples outputs only on falling edges. A read driven before edge k is checked at the falling edge after edge k+1, and write data is driven on the falling edge before edge k+2. A stalled edge moves every due slot back by one edge, and the stall checks sample exactly at the shifted slots. The output-enable and sleep checks are the only checks made in the middle of a cycle, one time unit after the asynchronous input changes, because those two inputs act on `dout_oe` with no clock edge.

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int AW     = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic             burst_ilv,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic             s1_v, s1_wr, s2_v, s2_wr;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_ln, s2_ln;
  logic [DW-1:0]    dq;

  logic          b_on, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic             sel, hit;
  logic [1:0]       nxt_cnt, nxt_lo;
  logic             cap_v, cap_wr;
  logic [AW-1:0]    cap_a;
  logic [DW-1:0]    rd_word;

  assign sel     = ~sel_a_n & sel_b & ~sel_c_n;
  assign nxt_cnt = b_cnt + 2'd1;
  assign nxt_lo  = burst_ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);

  assign cap_v  = ~sleep & (load_n ? b_on : sel);
  assign cap_a  = load_n ? {b_base[AW-1:2], nxt_lo} : addr;
  assign cap_wr = load_n ? b_wr : ~wr_n;

  assign hit = s2_v & s2_wr & (s2_a == s1_a);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (hit & s2_ln[g]) ? din[g*LANE_W +: LANE_W]
                                                         : mem[s1_a][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_ln <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_ln <= '0;
      dq <= '0;
      b_on <= 1'b0; b_wr <= 1'b0; b_base <= '0; b_cnt <= '0;
    end else if (!stall) begin
      s1_v  <= cap_v;
      s1_wr <= cap_wr;
      s1_a  <= cap_a;
      s1_ln <= ~lane_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_ln <= s1_ln;
      if (s1_v && !s1_wr) dq <= rd_word;
      if (sleep) begin
        b_on <= 1'b0;
      end else if (!load_n) begin
        b_on   <= sel;
        b_wr   <= ~wr_n;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (b_on) begin
        b_cnt <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !stall && !sleep && s2_v && s2_wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (s2_ln[i]) mem[s2_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dout    = dq;
  assign dout_oe = s2_v & ~s2_wr & ~out_en_n & ~sleep;

  assert_read_advance_R1: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_wr && !stall) |=> (s2_v && !s2_wr));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(dout));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !sel && !stall) |=> !s1_v);

  assert_continue_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !b_on && !stall) |=> !s1_v);

  assert_sleep_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (sleep && !stall) |=> (!s1_v && !b_on));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> (!dout_oe && !s1_v && !s2_v));
endmodule

// File: tb/pipe_sram_bench.sv
module pipe_sram_bench;
  logic        clk = 1'b0;
  logic        rst, stall, load_n, wr_n, sel_a_n, sel_b, sel_c_n;
  logic [1:0]  lane_n;
  logic [3:0]  addr;
  logic [17:0] din;
  logic        out_en_n, sleep, burst_ilv;
  logic [17:0] dout;
  logic        dout_oe;

  logic        so_oe;
  logic [17:0] so_d;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_sram u_pipe_sram (
    .clk(clk), .rst(rst), .stall(stall), .load_n(load_n), .wr_n(wr_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .lane_n(lane_n),
    .addr(addr), .din(din), .out_en_n(out_en_n), .sleep(sleep),
    .burst_ilv(burst_ilv), .dout(dout), .dout_oe(dout_oe)
  );

  // row: ld_n, wr_n, deselect, lane_n, addr, din, exp_oe, exp_dout
  localparam int NROW = 15;
  localparam logic [45:0] TBL [NROW] = '{
    {1'b0, 1'b0, 1'b0, 2'b00, 4'd3, 18'h00000, 1'b0, 18'h00000}, // R10 idle after reset
    {1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 18'h00000, 1'b0, 18'h00000},
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 18'h12345, 1'b0, 18'h00000}, // R2 data for A3
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 18'h2ABCD, 1'b0, 18'h00000}, // R2 data for A5
    {1'b0, 1'b0, 1'b0, 2'b10, 4'd3, 18'h00000, 1'b1, 18'h12345}, // R1 read A3
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 18'h00000, 1'b1, 18'h2ABCD}, // R1 read A5
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd5, 18'h3FFFF, 1'b0, 18'h00000}, // R5 lane 0 only
    {1'b0, 1'b1, 1'b1, 2'b00, 4'd0, 18'h00000, 1'b1, 18'h123FF}, // R9 forwarded merge
    {1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 18'h00000, 1'b1, 18'h2ABCD}, // R1 back-to-back read
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 18'h00000, 1'b0, 18'h00000}, // R4 deselect slot
    {1'b0, 1'b0, 1'b0, 2'b11, 4'd3, 18'h00000, 1'b0, 18'h00000}, // R4 continue stays off
    {1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 18'h00000, 1'b1, 18'h123FF}, // R1 first read after deselect
    {1'b0, 1'b1, 1'b1, 2'b00, 4'd0, 18'h3FFFF, 1'b0, 18'h00000}, // R5 abort slot
    {1'b0, 1'b1, 1'b1, 2'b00, 4'd0, 18'h00000, 1'b1, 18'h123FF}, // R5 abort wrote nothing
    {1'b0, 1'b1, 1'b1, 2'b00, 4'd0, 18'h00000, 1'b0, 18'h00000}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input logic oe_act, input logic oe_exp,
                     input logic [17:0] d_act, input logic [17:0] d_exp);
    checks++;
    if (oe_act !== oe_exp || (oe_exp && d_act !== d_exp)) begin
      errors++;
      $display("FAIL %s: oe=%0b dout=%h, expected oe=%0b dout=%h",
               req, oe_act, d_act, oe_exp, d_exp);
    end
  endtask

  task automatic step(input logic ld, input logic w, input logic dsl,
                      input logic [1:0] ln, input logic [3:0] a, input logic [17:0] d);
    @(negedge clk);
    so_oe   = dout_oe;
    so_d    = dout;
    load_n  = ld;
    wr_n    = w;
    sel_a_n = 1'b0;
    sel_b   = ~dsl;
    sel_c_n = 1'b0;
    lane_n  = ln;
    addr    = a;
    din     = d;
  endtask

  task automatic nop(input logic [17:0] d);
    step(1'b0, 1'b1, 1'b1, 2'b11, 4'd0, d);
  endtask

  function automatic logic [17:0] val(input logic [3:0] a);
    return 18'h20000 + 18'(a) * 18'h111;
  endfunction

  task automatic burst_read(input logic [3:0] a0, input logic ilv, input logic [3:0] e0,
                            input logic [3:0] e1, input logic [3:0] e2, input logic [3:0] e3);
    logic [3:0] ex [4];
    ex = '{e0, e1, e2, e3};
    burst_ilv = ilv;
    for (int k = 0; k < 6; k++) begin
      if (k == 0)     step(1'b0, 1'b1, 1'b0, 2'b11, a0, 18'h0);
      else if (k < 4) step(1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 18'h0);
      else            nop(18'h0);
      if (k >= 2) chk(ilv ? "R8 interleaved beat" : "R8 linear beat", so_oe, 1'b1, so_d, val(ex[k-2]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stall = 1'b0; load_n = 1'b0; wr_n = 1'b1;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; lane_n = 2'b11;
    addr = '0; din = '0; out_en_n = 1'b0; sleep = 1'b0; burst_ilv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", dout_oe, 1'b0, dout, 18'h0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      step(TBL[i][45], TBL[i][44], TBL[i][43], TBL[i][42:41], TBL[i][40:37], TBL[i][36:19]);
      chk($sformatf("R1/R2/R4/R5/R9 table row %0d", i), so_oe, TBL[i][18], so_d, TBL[i][17:0]);
    end

    // R3: stall freezes output and drops the command latched on stalled edges
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    nop(18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    stall = 1'b1;
    chk("R3 before stall", so_oe, 1'b1, so_d, 18'h2ABCD);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    chk("R3 held through stall", so_oe, 1'b1, so_d, 18'h2ABCD);
    nop(18'h0);
    stall = 1'b0;
    chk("R3 held through second stall", so_oe, 1'b1, so_d, 18'h2ABCD);
    nop(18'h0);
    chk("R3 pipeline resumes", so_oe, 1'b0, so_d, 18'h0);
    nop(18'h0);
    chk("R3 stalled load ignored", so_oe, 1'b0, so_d, 18'h0);

    // R3: write waiting for data takes din from the first unstalled edge
    step(1'b0, 1'b0, 1'b0, 2'b00, 4'd9, 18'h0);
    nop(18'h0);
    nop(18'h3FFFF);
    stall = 1'b1;
    nop(18'h0F0F0);
    stall = 1'b0;
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd9, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R3 write after stall", so_oe, 1'b1, so_d, 18'h0F0F0);

    // R6: asynchronous output enable
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R6 read due", so_oe, 1'b1, so_d, 18'h2ABCD);
    out_en_n = 1'b1;
    #1 chk("R6 disable without edge", dout_oe, 1'b0, dout, 18'h0);
    out_en_n = 1'b0;
    #1 chk("R6 re-enable without edge", dout_oe, 1'b1, dout, 18'h2ABCD);
    out_en_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R6 bus off while disabled", so_oe, 1'b0, so_d, 18'h0);
    out_en_n = 1'b0;
    #1 chk("R6 pipeline ran while disabled", dout_oe, 1'b1, dout, 18'h123FF);

    // R5: upper lane only
    step(1'b0, 1'b0, 1'b0, 2'b01, 4'd3, 18'h0);
    nop(18'h0);
    nop(18'h00000);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R5 lane 1 write", so_oe, 1'b1, so_d, 18'h001FF);

    // R8: linear write burst from 9 covers 9,10,11,8
    burst_ilv = 1'b0;
    step(1'b0, 1'b0, 1'b0, 2'b00, 4'd9, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, val(4'd9));
    step(1'b1, 1'b1, 1'b0, 2'b00, 4'd0, val(4'd10));
    nop(val(4'd11));
    nop(val(4'd8));
    burst_read(4'd11, 1'b1, 4'd11, 4'd10, 4'd9, 4'd8);
    burst_read(4'd10, 1'b0, 4'd10, 4'd11, 4'd8, 4'd9);

    // R7: sleep
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    nop(18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    sleep = 1'b1;
    chk("R7 read due before sleep", so_oe, 1'b1, so_d, 18'h2ABCD);
    #1 chk("R7 bus off in sleep", dout_oe, 1'b0, dout, 18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 18'h0);
    sleep = 1'b0;
    chk("R7 loads ignored in sleep", so_oe, 1'b0, so_d, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 18'h0);
    chk("R7 loads ignored in sleep", so_oe, 1'b0, so_d, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 18'h0);
    chk("R7 no resume without load", so_oe, 1'b0, so_d, 18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    chk("R7 no resume without load", so_oe, 1'b0, so_d, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R7 contents kept", so_oe, 1'b1, so_d, 18'h2ABCD);

    // R10: reset drops a pending write
    step(1'b0, 1'b0, 1'b0, 2'b00, 4'd12, 18'h0);
    nop(18'h0);
    nop(18'h15555);
    step(1'b0, 1'b0, 1'b0, 2'b00, 4'd12, 18'h0);
    nop(18'h0);
    rst = 1'b1;
    nop(18'h3FFFF);
    nop(18'h3FFFF);
    rst = 1'b0;
    chk("R10 bus off after reset", so_oe, 1'b0, so_d, 18'h0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd0, 18'h0);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd12, 18'h0);
    chk("R10 no burst after reset", so_oe, 1'b0, so_d, 18'h0);
    nop(18'h0);
    nop(18'h0);
    chk("R10 pending write not committed", so_oe, 1'b1, so_d, 18'h15555);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule